// File: doc/BRIEF.md
# Address Step Unit with Hold and Low-Bit Limit

This block sits between an address latch and the address pins of a processor core. A load strobe captures a 16-bit value from the internal register bus into the latch. A ripple carry chain then forms the latch value plus one, minus one, or the value unchanged. The stepped value can be driven back onto the register bus through its own output enable. A pin multiplexer with two select inputs puts either the stepped value or the raw latch value on the address pins.

A step takes place only when a step request is present and the core is not holding. Hold is the OR of three state inputs: halted, servicing a maskable interrupt, and servicing a non-maskable interrupt. The direction comes either from a plain direction input or from opcode bit 3, depending on a mode input. A limit mode stops the carry at bit 6, so only the low six bits count and wrap, as a refresh counter needs, while bits 15..6 pass through unchanged.

Top module: `addrstep_top`

## Requirements
- R1: On a rising clock edge with `latchLoad` high, the latch takes `busIn`. With `latchLoad` low the latch keeps its value. Reset clears the latch to 0x0000.
- R2: When `stepReq` is low, the stepped value equals the latch value exactly.
- R3: An increment step yields latch+1 modulo 2^16, so 0xFFFF becomes 0x0000.
- R4: With `dirFromOp` low, `dirDec`=1 selects decrement, giving latch-1 modulo 2^16 (0x0000 becomes 0xFFFF), and `dirDec`=0 selects increment.
- R5: With `dirFromOp` high, `opBit3`=1 selects decrement and `opBit3`=0 selects increment, and `dirDec` is ignored.
- R6: When any one of `haltState`, `intState` or `nmiState` is high, no step takes place and the stepped value equals the latch value.
- R7: With `limitMode` high, bits 5..0 step modulo 64 in either direction and bits 15..6 equal the latch's bits 15..6.
- R8: With `incBusOe` high, `busOut` carries the stepped value. Otherwise `busOut` is 0x0000.
- R9: With `pinSelInc` high, `pinAddr` is the stepped value, whatever `pinSelLatch` is. Otherwise, with `pinSelLatch` high, `pinAddr` is the latch value. With both selects low, `pinAddr` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busIn | input | 16 | Register bus value to load into the latch |
| latchLoad | input | 1 | Latch write strobe |
| stepReq | input | 1 | Request a step this cycle |
| dirDec | input | 1 | Direction: 1 decrement, 0 increment |
| dirFromOp | input | 1 | Take direction from opcode bit 3 instead of dirDec |
| opBit3 | input | 1 | Opcode bit 3 |
| limitMode | input | 1 | Confine the carry to bits 5..0 |
| haltState | input | 1 | Core is halted |
| intState | input | 1 | Core is servicing a maskable interrupt |
| nmiState | input | 1 | Core is servicing a non-maskable interrupt |
| incBusOe | input | 1 | Drive the stepped value onto busOut |
| pinSelInc | input | 1 | Address pins from the stepped value (priority) |
| pinSelLatch | input | 1 | Address pins from the raw latch value |
| busOut | output | 16 | Stepped value or zero |
| pinAddr | output | 16 | Address pin value |

## Verification
The checker enforces these rules on every cycle:
- the latch loads on the strobe and holds without it;
- a hold state pins the stepped address to the latch;
- limit mode never disturbs bits 15..6;
- the idle bus reads zero;
- latch-only pin selection passes the latch through;
- a plain increment gives the latch plus one.

The bench scenarios cover the rest. They exercise both wrap boundaries, and direction taken from the opcode bit with the plain direction input set against it. They also cover wrapping of the low six bits in each direction under limit mode, each hold source on its own, and the precedence when both pin selects are high.

// File: rtl/addrstep_pkg.sv
package addrstep_pkg;

  // Step strobes from control to datapath
  typedef struct packed {
    logic carryIn;   // a step is taken this cycle
    logic decrement; // 1: subtract one, 0: add one
    logic limitLow;  // kill the carry above the low field
  } stepStrobe_t;

  typedef enum logic [1:0] {
    PIN_IDLE  = 2'd0,
    PIN_LATCH = 2'd1,
    PIN_STEP  = 2'd2
  } pinSrc_t;

  typedef struct packed {
    stepStrobe_t step;
    pinSrc_t     pinSrc;
    logic        busOe;
  } ctrlStrobe_t;

endpackage

// File: rtl/addrstep_ctrl.sv
module addrstep_ctrl
  import addrstep_pkg::*;
(
  input  logic        stepReq,
  input  logic        dirDec,
  input  logic        dirFromOp,
  input  logic        opBit3,
  input  logic        limitMode,
  input  logic        haltState,
  input  logic        intState,
  input  logic        nmiState,
  input  logic        incBusOe,
  input  logic        pinSelInc,
  input  logic        pinSelLatch,
  output ctrlStrobe_t strobe
);

  logic holdStep;
  logic dirSel;

  // Any of the three service/halt states blocks the step
  assign holdStep = haltState | intState | nmiState;

  // Direction source is picked by mode
  assign dirSel = dirFromOp ? opBit3 : dirDec;

  always_comb begin
    strobe                = '0;
    strobe.step.carryIn   = stepReq & ~holdStep;
    strobe.step.decrement = dirSel;
    strobe.step.limitLow  = limitMode;
    strobe.busOe          = incBusOe;
    if (pinSelInc)        strobe.pinSrc = PIN_STEP;
    else if (pinSelLatch) strobe.pinSrc = PIN_LATCH;
    else                  strobe.pinSrc = PIN_IDLE;
  end

endmodule

// File: rtl/addrstep_dpath.sv
module addrstep_dpath
  import addrstep_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int LIMIT_BITS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] busIn,
  input  logic             latchLoad,
  input  ctrlStrobe_t      strobe,
  output logic [WIDTH-1:0] latchQ,
  output logic [WIDTH-1:0] busOut,
  output logic [WIDTH-1:0] pinAddr
);

  localparam int CUT = LIMIT_BITS - 1;

  logic [WIDTH-1:0] stepped;
  logic [WIDTH:0]   carry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          latchQ <= '0;
    else if (latchLoad) latchQ <= busIn;
  end

  assign carry[0] = strobe.step.carryIn;

  // Ripple chain: a borrow passes through a zero bit, a carry through a one bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    logic passBit;
    assign passBit    = strobe.step.decrement ? ~latchQ[i] : latchQ[i];
    assign stepped[i] = latchQ[i] ^ carry[i];
    if (i == CUT) begin : g_cut
      assign carry[i+1] = passBit & carry[i] & ~strobe.step.limitLow;
    end else begin : g_pass
      assign carry[i+1] = passBit & carry[i];
    end
  end

  assign busOut = strobe.busOe ? stepped : '0;

  always_comb begin
    unique case (strobe.pinSrc)
      PIN_STEP:  pinAddr = stepped;
      PIN_LATCH: pinAddr = latchQ;
      default:   pinAddr = '0;
    endcase
  end

endmodule

// File: rtl/addrstep_top.sv
module addrstep_top
  import addrstep_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int LIMIT_BITS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] busIn,
  input  logic             latchLoad,
  input  logic             stepReq,
  input  logic             dirDec,
  input  logic             dirFromOp,
  input  logic             opBit3,
  input  logic             limitMode,
  input  logic             haltState,
  input  logic             intState,
  input  logic             nmiState,
  input  logic             incBusOe,
  input  logic             pinSelInc,
  input  logic             pinSelLatch,
  output logic [WIDTH-1:0] busOut,
  output logic [WIDTH-1:0] pinAddr
);

  ctrlStrobe_t      strobe;
  logic [WIDTH-1:0] latchQ;

  addrstep_ctrl u_ctrl (
    .stepReq     (stepReq),
    .dirDec      (dirDec),
    .dirFromOp   (dirFromOp),
    .opBit3      (opBit3),
    .limitMode   (limitMode),
    .haltState   (haltState),
    .intState    (intState),
    .nmiState    (nmiState),
    .incBusOe    (incBusOe),
    .pinSelInc   (pinSelInc),
    .pinSelLatch (pinSelLatch),
    .strobe      (strobe)
  );

  addrstep_dpath #(.WIDTH(WIDTH), .LIMIT_BITS(LIMIT_BITS)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .busIn     (busIn),
    .latchLoad (latchLoad),
    .strobe    (strobe),
    .latchQ    (latchQ),
    .busOut    (busOut),
    .pinAddr   (pinAddr)
  );

endmodule

// File: rtl/addrstep_chk.sv
module addrstep_chk #(
  parameter int WIDTH      = 16,
  parameter int LIMIT_BITS = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] busIn,
  input logic             latchLoad,
  input logic [WIDTH-1:0] latchQ,
  input logic             stepReq,
  input logic             dirDec,
  input logic             dirFromOp,
  input logic             limitMode,
  input logic             haltState,
  input logic             intState,
  input logic             nmiState,
  input logic             incBusOe,
  input logic             pinSelInc,
  input logic             pinSelLatch,
  input logic [WIDTH-1:0] busOut,
  input logic [WIDTH-1:0] pinAddr
);

  // R1
  latch_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchLoad |=> latchQ == $past(busIn));

  // R1
  latch_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !latchLoad |=> $stable(latchQ));

  // R6
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((haltState | intState | nmiState) && pinSelInc) |-> pinAddr == latchQ);

  // R7
  limit_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (limitMode && pinSelInc) |-> pinAddr[WIDTH-1:LIMIT_BITS] == latchQ[WIDTH-1:LIMIT_BITS]);

  // R8
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !incBusOe |-> busOut == '0);

  // R9
  pin_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pinSelInc && pinSelLatch) |-> pinAddr == latchQ);

  // R3
  plain_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinSelInc && stepReq && !(haltState | intState | nmiState) && !limitMode
     && !dirFromOp && !dirDec) |-> pinAddr == latchQ + 1'b1);

endmodule

bind addrstep_top addrstep_chk #(.WIDTH(WIDTH), .LIMIT_BITS(LIMIT_BITS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busIn       (busIn),
  .latchLoad   (latchLoad),
  .latchQ      (latchQ),
  .stepReq     (stepReq),
  .dirDec      (dirDec),
  .dirFromOp   (dirFromOp),
  .limitMode   (limitMode),
  .haltState   (haltState),
  .intState    (intState),
  .nmiState    (nmiState),
  .incBusOe    (incBusOe),
  .pinSelInc   (pinSelInc),
  .pinSelLatch (pinSelLatch),
  .busOut      (busOut),
  .pinAddr     (pinAddr)
);

// File: tb/addrstep_top_bench.sv
module addrstep_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busIn = '0;
  logic        latchLoad = 1'b0;
  logic        stepReq = 1'b0, dirDec = 1'b0, dirFromOp = 1'b0, opBit3 = 1'b0;
  logic        limitMode = 1'b0, haltState = 1'b0, intState = 1'b0, nmiState = 1'b0;
  logic        incBusOe = 1'b0, pinSelInc = 1'b0, pinSelLatch = 1'b0;
  logic [15:0] busOut, pinAddr;

  int checks = 0;
  int failures = 0;
  logic [15:0] base = '0;

  always #10 clk = ~clk;

  addrstep_top u_addrstep_top (
    .clk(clk), .rstN(rstN), .busIn(busIn), .latchLoad(latchLoad),
    .stepReq(stepReq), .dirDec(dirDec), .dirFromOp(dirFromOp), .opBit3(opBit3),
    .limitMode(limitMode), .haltState(haltState), .intState(intState),
    .nmiState(nmiState), .incBusOe(incBusOe), .pinSelInc(pinSelInc),
    .pinSelLatch(pinSelLatch), .busOut(busOut), .pinAddr(pinAddr)
  );

  function automatic logic [15:0] stepModel(logic [15:0] v);
    logic d;
    logic [5:0] low;
    if (!stepReq || haltState || intState || nmiState) return v;
    d = dirFromOp ? opBit3 : dirDec;
    if (limitMode) begin
      low = d ? v[5:0] - 6'd1 : v[5:0] + 6'd1;
      return {v[15:6], low};
    end
    return d ? v - 16'd1 : v + 16'd1;
  endfunction

  function automatic logic [15:0] pinModel(logic [15:0] v);
    if (pinSelInc)   return stepModel(v);
    if (pinSelLatch) return v;
    return 16'h0000;
  endfunction

  task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadLatch(logic [15:0] v);
    @(negedge clk);
    busIn = v;
    latchLoad = 1'b1;
    @(negedge clk);
    latchLoad = 1'b0;
    base = v;
  endtask

  task automatic setCtl(logic st, logic dd, logic fo, logic o3, logic lm,
                        logic h, logic i, logic n);
    stepReq = st; dirDec = dd; dirFromOp = fo; opBit3 = o3; limitMode = lm;
    haltState = h; intState = i; nmiState = n;
    #2;
  endtask

  task automatic checkBoth(string req);
    check16(req, pinAddr, pinModel(base));
    check16(req, busOut, incBusOe ? stepModel(base) : 16'h0000);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd5151));
    pinSelLatch = 1'b1;
    #1;
    // R1 reset state
    check16("R1 reset", pinAddr, 16'h0000);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    incBusOe = 1'b1;
    pinSelInc = 1'b1;

    // R2 no step request
    loadLatch(16'h1234);
    setCtl(0, 0, 0, 0, 0, 0, 0, 0);
    check16("R2", pinAddr, 16'h1234);
    check16("R2", busOut, 16'h1234);

    // R3 increment wrap
    loadLatch(16'hFFFF);
    setCtl(1, 0, 0, 0, 0, 0, 0, 0);
    check16("R3", pinAddr, 16'h0000);

    // R4 decrement wrap
    loadLatch(16'h0000);
    setCtl(1, 1, 0, 0, 0, 0, 0, 0);
    check16("R4", busOut, 16'hFFFF);

    // R5 opcode bit picks direction, dirDec ignored
    loadLatch(16'h0100);
    setCtl(1, 0, 1, 1, 0, 0, 0, 0);
    check16("R5", pinAddr, 16'h00FF);
    setCtl(1, 1, 1, 0, 0, 0, 0, 0);
    check16("R5", pinAddr, 16'h0101);

    // R6 each hold source
    loadLatch(16'h4000);
    setCtl(1, 0, 0, 0, 0, 1, 0, 0);
    check16("R6 halt", pinAddr, 16'h4000);
    setCtl(1, 0, 0, 0, 0, 0, 1, 0);
    check16("R6 int", pinAddr, 16'h4000);
    setCtl(1, 1, 0, 0, 0, 0, 0, 1);
    check16("R6 nmi", busOut, 16'h4000);

    // R7 limit mode in both directions
    loadLatch(16'h80BF);
    setCtl(1, 0, 0, 0, 1, 0, 0, 0);
    check16("R7 inc", pinAddr, 16'h8080);
    loadLatch(16'h0040);
    setCtl(1, 1, 0, 0, 1, 0, 0, 0);
    check16("R7 dec", pinAddr, 16'h007F);

    // R8 bus disabled
    incBusOe = 1'b0;
    setCtl(1, 0, 0, 0, 0, 0, 0, 0);
    check16("R8", busOut, 16'h0000);
    incBusOe = 1'b1;

    // R9 pin select combinations
    pinSelInc = 1'b0; pinSelLatch = 1'b0;
    #2 check16("R9 idle", pinAddr, 16'h0000);
    pinSelLatch = 1'b1;
    #2 check16("R9 latch", pinAddr, 16'h0040);
    pinSelInc = 1'b1;
    #2 check16("R9 both", pinAddr, 16'h0041);

    // R1 latch holds while busIn moves without a strobe
    @(negedge clk);
    busIn = 16'hBEEF;
    @(negedge clk);
    setCtl(0, 0, 0, 0, 0, 0, 0, 0);
    check16("R1 hold", pinAddr, 16'h0040);

    // Random mix over all requirements
    for (int k = 0; k < 400; k++) begin
      loadLatch(16'($urandom));
      incBusOe = 1'($urandom); pinSelInc = 1'($urandom); pinSelLatch = 1'($urandom);
      setCtl(1'($urandom % 4 != 0), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom % 3 == 0), 1'($urandom % 6 == 0), 1'($urandom % 6 == 0),
             1'($urandom % 6 == 0));
      checkBoth("R2-R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule